// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block performs the eight shift and rotate operations of a general-purpose integer datapath on byte, word or long operands. It returns the result clipped to the operand size, together with the five condition flags: carry (C), overflow (V), zero (Z), negative (N) and extend (X). The caller presents the operand, the size, the operation, a count source and the current X flag, and pulses `start`. The unit then moves one bit per clock and pulses `done` when the registered result and flags are valid.

There are three ways to supply the count: a 3-bit immediate field, a general register, or the single-bit memory form. The memory form always works on a word and shifts by one. Counts taken from a register can reach 63, which is well beyond the operand width. The flag rules follow that range exactly. C holds the last bit that crossed the operand edge. V on an arithmetic left shift records any change of the sign bit along the way. The rotate-through-extend forms treat X as one extra bit above the operand.

Top module: `shr_unit`

## Requirements
- R1: The count is taken in one of two ways. When `use_reg_cnt` is 1, it is the low 6 bits of `reg_cnt` (the register value modulo 64). Otherwise it is the 3-bit `imm_cnt`, where a field of 0 means a count of 8 and 1 to 7 mean themselves.
- R2: When `mem_form` is 1, the operation uses word size and a count of exactly 1, whatever `size`, `imm_cnt`, `use_reg_cnt` and `reg_cnt` hold.
- R3: The operation codes on `op` are 0 arithmetic left, 1 arithmetic right, 2 logical left, 3 logical right, 4 rotate left, 5 rotate right, 6 rotate left through X, and 7 rotate right through X. C is the last bit moved out of the operand. With a count of zero, C is 0 for codes 0 to 5.
- R4: For arithmetic left (code 0), V is 1 if the top bit of the operand size differs between any two consecutive steps of the shift. Otherwise V is 0.
- R5: For codes 1 to 7, V is 0.
- R6: Arithmetic right (code 1) copies the size's top bit back into that top bit on every step.
- R7: For codes 0 to 3, X takes the final C when the count is nonzero and keeps `x_in` when the count is zero. For codes 4 and 5, X always equals `x_in`.
- R8: For codes 6 and 7, `x_in` acts as an extra bit beyond the operand's top bit and X equals the final C. With a count of zero, C equals `x_in`.
- R9: The size codes are 0 byte, 1 word, and 2 or 3 long. The result has every bit above the size cleared, operand bits above the size have no effect, Z is 1 exactly when the clipped result is zero, and N is the size's top bit of the result.
- R10: When `start` is accepted while idle, `busy` is 1 from the next cycle. `done`, the new `result` and the new flags appear max(count,1) clock edges after the accepting edge. `done` lasts one cycle and is never high together with `busy`.
- R11: `start` is ignored while `busy` is 1. `result` and the flags change only in a cycle where `done` is 1.
- R12: Synchronous reset clears `busy`, `done`, `result` and all five flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches an operation when idle |
| op | input | 3 | Operation code (see R3) |
| size | input | 2 | Operand size code (see R9) |
| mem_form | input | 1 | Single-bit word form: word size, count 1 |
| use_reg_cnt | input | 1 | Selects the register count over the immediate |
| imm_cnt | input | 3 | Immediate count field, 0 meaning 8 |
| reg_cnt | input | 32 | Register holding the count, low 6 bits used |
| operand | input | 32 | Value to shift or rotate |
| x_in | input | 1 | Current extend flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result and flags updated |
| result | output | 32 | Size-clipped result |
| flag_c | output | 1 | Carry |
| flag_v | output | 1 | Overflow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_x | output | 1 | Extend |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 6-bit count and a 3-bit immediate field. These values let counts run past the long width, up to 33 steps, so a value can be shifted right out of a long. The one-bit immediate-as-eight case and register values that wrap modulo 64 to 1 and to 0 are also reachable. With these widths, byte and word clipping of a wider operand and the overflow rule can be observed at all three sizes. The latency of each vector is measured in clock edges against max(count,1). A second start launched in the middle of a long operation tests that the unit does not take new work while busy.

// File: rtl/shr_pkg.sv
package shr_pkg;

  typedef enum logic [2:0] {
    OP_ASL = 3'd0,
    OP_ASR = 3'd1,
    OP_LSL = 3'd2,
    OP_LSR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RXL = 3'd6,
    OP_RXR = 3'd7
  } shr_op_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  // Index of the sign bit for a size code, given the full datapath width.
  function automatic int unsigned msb_index(logic [1:0] sz, int unsigned w);
    case (sz)
      SZ_BYTE: return w / 4 - 1;
      SZ_WORD: return w / 2 - 1;
      default: return w - 1;
    endcase
  endfunction

  function automatic logic is_shift(shr_op_e o);
    return (o == OP_ASL) || (o == OP_ASR) || (o == OP_LSL) || (o == OP_LSR);
  endfunction

endpackage

// File: rtl/shr_count_sel.sv
module shr_count_sel #(
  parameter int CNT_W = 6,
  parameter int IMM_W = 3,
  parameter int REG_W = 32
) (
  input  logic             mem_form,
  input  logic             use_reg,
  input  logic [IMM_W-1:0] imm_cnt,
  input  logic [REG_W-1:0] reg_cnt,
  input  logic [1:0]       size_in,
  output logic [CNT_W-1:0] count,
  output logic [1:0]       size_out
);
  import shr_pkg::*;

  localparam logic [CNT_W-1:0] IMM_ZERO_MEANS = CNT_W'(1) << IMM_W;

  always_comb begin
    if (mem_form) begin
      count    = CNT_W'(1);
      size_out = SZ_WORD;
    end else begin
      size_out = size_in;
      if (use_reg)
        count = reg_cnt[CNT_W-1:0];
      else if (imm_cnt == '0)
        count = IMM_ZERO_MEANS;
      else
        count = CNT_W'(imm_cnt);
    end
  end

endmodule

// File: rtl/shr_step.sv
module shr_step #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] acc,
  input  logic              carry_in,
  input  shr_pkg::shr_op_e  op,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] acc_nxt,
  output logic              bit_out,
  output logic              sign_flip
);
  import shr_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0]  tb;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] raw;
  logic              hi_bit;
  logic              lo_bit;

  always_comb begin
    tb     = IDX_W'(msb_index(size, DATA_W));
    mask   = {DATA_W{1'b1}} >> (IDX_W'(DATA_W - 1) - tb);
    hi_bit = acc[tb];
    lo_bit = acc[0];
    raw    = acc >> 1;
    case (op)
      OP_ASL, OP_LSL: begin
        bit_out = hi_bit;
        raw     = acc << 1;
      end
      OP_ASR: begin
        bit_out = lo_bit;
        raw[tb] = hi_bit;
      end
      OP_LSR: begin
        bit_out = lo_bit;
      end
      OP_ROL: begin
        bit_out = hi_bit;
        raw     = (acc << 1) | DATA_W'(hi_bit);
      end
      OP_ROR: begin
        bit_out = lo_bit;
        raw[tb] = lo_bit;
      end
      OP_RXL: begin
        bit_out = hi_bit;
        raw     = (acc << 1) | DATA_W'(carry_in);
      end
      default: begin
        bit_out = lo_bit;
        raw[tb] = carry_in;
      end
    endcase
    acc_nxt   = raw & mask;
    sign_flip = hi_bit ^ acc_nxt[tb];
  end

endmodule

// File: rtl/shr_flags.sv
module shr_flags #(
  parameter int DATA_W = 32
) (
  input  shr_pkg::shr_op_e  op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] acc,
  input  logic              carry,
  input  logic              ovf,
  input  logic              x_in,
  input  logic              cnt_nz,
  output logic              c,
  output logic              v,
  output logic              z,
  output logic              n,
  output logic              x
);
  import shr_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0] tb;

  always_comb begin
    tb = IDX_W'(msb_index(size, DATA_W));
    c  = carry;
    v  = (op == OP_ASL) && ovf;
    z  = (acc == '0);
    n  = acc[tb];
    if (is_shift(op))
      x = cnt_nz ? carry : x_in;
    else if (op == OP_ROL || op == OP_ROR)
      x = x_in;
    else
      x = carry;
  end

endmodule

// File: rtl/shr_unit.sv
module shr_unit #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6,
  parameter int IMM_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic              mem_form,
  input  logic              use_reg_cnt,
  input  logic [IMM_W-1:0]  imm_cnt,
  input  logic [DATA_W-1:0] reg_cnt,
  input  logic [DATA_W-1:0] operand,
  input  logic              x_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              flag_c,
  output logic              flag_v,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_x
);
  import shr_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);

  shr_op_e           op_in;
  logic [CNT_W-1:0]  sel_count;
  logic [1:0]        sel_size;
  logic [IDX_W-1:0]  load_tb;
  logic [DATA_W-1:0] load_mask;

  logic              busy_q, done_q;
  logic [CNT_W-1:0]  rem_q;
  logic [DATA_W-1:0] acc_q;
  logic              carry_q, ovf_q, x_q, cnt_nz_q;
  shr_op_e           op_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] result_q;
  logic              c_q, v_q, z_q, n_q, x_out_q;

  logic [DATA_W-1:0] step_acc;
  logic              step_out, step_flip;
  logic              stepping;
  logic [DATA_W-1:0] fin_acc;
  logic              fin_carry, fin_ovf;
  logic              fc, fv, fz, fn, fx;

  assign op_in = shr_op_e'(op);

  shr_count_sel #(.CNT_W(CNT_W), .IMM_W(IMM_W), .REG_W(DATA_W)) cnt_i (
    .mem_form (mem_form),
    .use_reg  (use_reg_cnt),
    .imm_cnt  (imm_cnt),
    .reg_cnt  (reg_cnt),
    .size_in  (size),
    .count    (sel_count),
    .size_out (sel_size)
  );

  shr_step #(.DATA_W(DATA_W)) step_i (
    .acc       (acc_q),
    .carry_in  (carry_q),
    .op        (op_q),
    .size      (size_q),
    .acc_nxt   (step_acc),
    .bit_out   (step_out),
    .sign_flip (step_flip)
  );

  assign stepping  = (rem_q != '0);
  assign fin_acc   = stepping ? step_acc : acc_q;
  assign fin_carry = stepping ? step_out : carry_q;
  assign fin_ovf   = ovf_q | (stepping & step_flip);

  shr_flags #(.DATA_W(DATA_W)) flags_i (
    .op     (op_q),
    .size   (size_q),
    .acc    (fin_acc),
    .carry  (fin_carry),
    .ovf    (fin_ovf),
    .x_in   (x_q),
    .cnt_nz (cnt_nz_q),
    .c      (fc),
    .v      (fv),
    .z      (fz),
    .n      (fn),
    .x      (fx)
  );

  always_comb begin
    load_tb   = IDX_W'(msb_index(sel_size, DATA_W));
    load_mask = {DATA_W{1'b1}} >> (IDX_W'(DATA_W - 1) - load_tb);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rem_q    <= '0;
      acc_q    <= '0;
      carry_q  <= 1'b0;
      ovf_q    <= 1'b0;
      x_q      <= 1'b0;
      cnt_nz_q <= 1'b0;
      op_q     <= OP_ASL;
      size_q   <= '0;
      result_q <= '0;
      c_q      <= 1'b0;
      v_q      <= 1'b0;
      z_q      <= 1'b0;
      n_q      <= 1'b0;
      x_out_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q   <= 1'b1;
          rem_q    <= sel_count;
          acc_q    <= operand & load_mask;
          carry_q  <= (op_in == OP_RXL || op_in == OP_RXR) ? x_in : 1'b0;
          ovf_q    <= 1'b0;
          x_q      <= x_in;
          cnt_nz_q <= (sel_count != '0);
          op_q     <= op_in;
          size_q   <= sel_size;
        end
      end else begin
        if (stepping) begin
          acc_q   <= step_acc;
          carry_q <= step_out;
          ovf_q   <= fin_ovf;
          rem_q   <= rem_q - CNT_W'(1);
        end
        if (rem_q <= CNT_W'(1)) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= fin_acc;
          c_q      <= fc;
          v_q      <= fv;
          z_q      <= fz;
          n_q      <= fn;
          x_out_q  <= fx;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = result_q;
  assign flag_c = c_q;
  assign flag_v = v_q;
  assign flag_z = z_q;
  assign flag_n = n_q;
  assign flag_x = x_out_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q));

  // R5
  v_only_arith_left_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && op_q != OP_ASL) |-> !v_q);

  // R7
  rotate_keeps_x_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && (op_q == OP_ROL || op_q == OP_ROR)) |-> (x_out_q == x_q));

  // R8
  rx_x_equals_c_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && (op_q == OP_RXL || op_q == OP_RXR)) |-> (x_out_q == c_q));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(result_q));

  // R1
  imm_count_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q && !use_reg_cnt) |-> (sel_count != '0));

endmodule

// File: tb/shr_unit_tb_top.sv
module shr_unit_tb_top;

  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;
  localparam int IMM_W  = 3;
  localparam int NVEC   = 16;

  typedef struct packed {
    logic [2:0]        op;
    logic [1:0]        sz;
    logic              mem;
    logic              sel;
    logic [IMM_W-1:0]  imm;
    logic [DATA_W-1:0] rc;
    logic [DATA_W-1:0] opnd;
    logic              x;
    logic [DATA_W-1:0] res;
    logic [4:0]        cvznx;
    logic [7:0]        cyc;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    // R4 sign change on single step
    '{3'd0, 2'd0, 1'b0, 1'b0, 3'd1, 32'd0, 32'h40, 1'b0, 32'h80, 5'b01010, 8'd1},
    // R4 change on second step
    '{3'd0, 2'd0, 1'b0, 1'b0, 3'd2, 32'd0, 32'hC0, 1'b0, 32'h00, 5'b11101, 8'd2},
    // R4 no change
    '{3'd0, 2'd1, 1'b0, 1'b0, 3'd3, 32'd0, 32'hF001, 1'b0, 32'h8008, 5'b10011, 8'd3},
    // R6 sign fill word
    '{3'd1, 2'd1, 1'b0, 1'b0, 3'd3, 32'd0, 32'h8005, 1'b0, 32'hF000, 5'b10011, 8'd3},
    // R1 immediate 0 is 8
    '{3'd1, 2'd0, 1'b0, 1'b0, 3'd0, 32'd0, 32'h7F, 1'b0, 32'h00, 5'b00100, 8'd8},
    // R3 logical right long
    '{3'd3, 2'd2, 1'b0, 1'b1, 3'd0, 32'd4, 32'h18, 1'b1, 32'h01, 5'b10001, 8'd4},
    // R7 zero count keeps X
    '{3'd2, 2'd2, 1'b0, 1'b1, 3'd0, 32'd0, 32'h80000000, 1'b1, 32'h80000000, 5'b00011, 8'd1},
    // R1 register 65 wraps to 1
    '{3'd2, 2'd1, 1'b0, 1'b1, 3'd0, 32'h41, 32'h4000, 1'b0, 32'h8000, 5'b00010, 8'd1},
    // R7 rotate by 8
    '{3'd4, 2'd0, 1'b0, 1'b0, 3'd0, 32'd0, 32'h81, 1'b0, 32'h81, 5'b10010, 8'd8},
    // R7 rotate right keeps X
    '{3'd5, 2'd1, 1'b0, 1'b0, 3'd1, 32'd0, 32'h0001, 1'b0, 32'h8000, 5'b10010, 8'd1},
    // R8 through X left
    '{3'd6, 2'd0, 1'b0, 1'b0, 3'd1, 32'd0, 32'h80, 1'b1, 32'h01, 5'b10001, 8'd1},
    // R8 zero count C from X
    '{3'd7, 2'd2, 1'b0, 1'b1, 3'd0, 32'd0, 32'h0, 1'b1, 32'h0, 5'b10101, 8'd1},
    // R8 through X right
    '{3'd7, 2'd0, 1'b0, 1'b0, 3'd2, 32'd0, 32'h01, 1'b0, 32'h80, 5'b00010, 8'd2},
    // R2 memory form, R9 clipping
    '{3'd1, 2'd0, 1'b1, 1'b0, 3'd5, 32'd0, 32'h12348001, 1'b0, 32'hC000, 5'b10011, 8'd1},
    // R4 long count 33
    '{3'd0, 2'd2, 1'b0, 1'b1, 3'd0, 32'd33, 32'h1, 1'b0, 32'h0, 5'b01100, 8'd33},
    // R3 register 64 wraps to 0
    '{3'd4, 2'd1, 1'b0, 1'b1, 3'd0, 32'h40, 32'h8001, 1'b1, 32'h8001, 5'b00011, 8'd1}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic [2:0]        op;
  logic [1:0]        size;
  logic              mem_form;
  logic              use_reg_cnt;
  logic [IMM_W-1:0]  imm_cnt;
  logic [DATA_W-1:0] reg_cnt;
  logic [DATA_W-1:0] operand;
  logic              x_in;
  logic              busy, done;
  logic [DATA_W-1:0] result;
  logic              flag_c, flag_v, flag_z, flag_n, flag_x;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  shr_unit #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IMM_W(IMM_W)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .op          (op),
    .size        (size),
    .mem_form    (mem_form),
    .use_reg_cnt (use_reg_cnt),
    .imm_cnt     (imm_cnt),
    .reg_cnt     (reg_cnt),
    .operand     (operand),
    .x_in        (x_in),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .flag_c      (flag_c),
    .flag_v      (flag_v),
    .flag_z      (flag_z),
    .flag_n      (flag_n),
    .flag_x      (flag_x)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op          = v.op;
    size        = v.sz;
    mem_form    = v.mem;
    use_reg_cnt = v.sel;
    imm_cnt     = v.imm;
    reg_cnt     = v.rc;
    operand     = v.opnd;
    x_in        = v.x;
  endtask

  // Launch at a negedge; return the number of edges until done is seen.
  task automatic launch_and_wait(input vec_t v, output int cyc);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      cyc++;
      if (done) break;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    rst = 1'b1;
    start = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 status", {62'd0, busy, done}, 64'd0);
    check("R12 result", 64'(result), 64'd0);
    check("R12 flags", 64'({flag_c, flag_v, flag_z, flag_n, flag_x}), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      launch_and_wait(VECS[i], cyc);
      check($sformatf("R10 latency vec%0d", i), 64'(cyc), 64'(VECS[i].cyc));
      check($sformatf("R9 result vec%0d", i), 64'(result), 64'(VECS[i].res));
      check($sformatf("R3 flags cvznx vec%0d", i),
            64'({flag_c, flag_v, flag_z, flag_n, flag_x}), 64'(VECS[i].cvznx));
      @(negedge clk);
      check($sformatf("R10 done pulse vec%0d", i), 64'(done), 64'd0);
    end

    // R11: second start while busy is ignored
    drive(VECS[14]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R10 busy during run", 64'(busy), 64'd1);
    repeat (3) @(negedge clk);
    drive(VECS[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 5;
    for (int k = 0; k < 100; k++) begin
      if (done) break;
      @(negedge clk);
      cyc++;
    end
    check("R11 latency unaffected", 64'(cyc), 64'd33);
    check("R11 result of first op", 64'(result), 64'd0);
    check("R11 flags of first op",
          64'({flag_c, flag_v, flag_z, flag_n, flag_x}), 64'(5'b01100));
    repeat (4) @(negedge clk);
    check("R11 no second completion", 64'({busy, done}), 64'd0);
    check("R11 result held", 64'(result), 64'd0);

    // R12 reset mid-operation
    drive(VECS[14]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12 reset aborts", 64'({busy, done}), 64'd0);
    check("R12 reset flags", 64'({flag_c, flag_v, flag_z, flag_n, flag_x}), 64'd0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule